// File: doc/BRIEF.md
# Card Write-Start FIFO Controller

This block sits between a host bus and a memory-card data engine. It holds one data FIFO that the host fills and the card engine drains on a write, and that the card engine fills and the host drains on a read. On a write it decides when the card-side transfer of each block may begin. The decision depends on a start mode and on how the programmed block length compares with the FIFO depth. It also raises underflow and overflow flags, which can be cleared in one of two ways. It holds a queued command back until a data block or a whole transfer has finished.

Software programs the configuration through a write strobe, which write protection can block. It opens a transfer with a command pulse that carries the direction and a block count, where a count of zero means the transfer has no end. The card engine watches `xfer_go` and pops words only while it is high. Card clocking, the CRC, the line protocol and DMA all stay outside the block.

The controller is one state machine with four states:
- `ST_IDLE`: no transfer is active.
- `ST_FILL`: a write block is waiting for enough data.
- `ST_RUN`: a write block is being sent.
- `ST_READ`: a read transfer is active.

Its transitions are:
- new command: any state goes to `ST_FILL` for a write and to `ST_READ` for a read.
- fill reached: `ST_FILL` goes to `ST_RUN` once the level is at or above the threshold.
- block done: `ST_RUN` goes back to `ST_FILL`.
- transfer done: `ST_RUN` or `ST_READ` goes to `ST_IDLE`.

Top module: `cardfifo_start_ctrl`

## Requirements
- R1: After reset the FIFO is empty and `xfer_go`, `flag_unf`, `flag_ovf` and `cmd_issue` are 0. The configuration resets to this state:
  - threshold start mode (`cfg_eager` = 0)
  - clear by command (`cfg_flag_rs` = 0)
  - block sync (`cfg_sync_xfer` = 0)
  - block length equal to DEPTH
- R2: With `cfg_eager` = 1, a write block starts (`xfer_go` = 1) once the FIFO holds at least one word.
- R3: With `cfg_eager` = 0 and a block length of at least 3*DEPTH/4, a write block starts once the FIFO level reaches DEPTH/2.
- R4: With `cfg_eager` = 0 and a block length from DEPTH/2 up to but not including 3*DEPTH/4, a write block starts once the level reaches DEPTH/4.
- R5: With `cfg_eager` = 0 and a block length below DEPTH/2, a write block starts only when the level equals the block length. All thresholds use integer division.
- R6: `xfer_go` stays 1 until the card has consumed the last word of the block. The start decision is then made again for the next block, or the block returns to idle after the last block. A block count of 0 means the transfer never ends.
- R7: A `card_pop` while `xfer_go` is 1 and the FIFO is empty sets `flag_unf`. That pop does not count as a consumed word.
- R8: A `card_push` during a read while the FIFO is full sets `flag_ovf`. The word is dropped and not counted.
- R9: With `cfg_flag_rs` = 0, only a new command (`cmd_new`) clears the flags. `stat_rd` has no effect on them.
- R10: With `cfg_flag_rs` = 1, only `stat_rd` clears the flags. `cmd_new` has no effect on them. If a flag is set and cleared in the same cycle, the set wins.
- R11: A command queued by `cmd_pend` produces a one-cycle `cmd_issue` in the cycle after the end of the current data block when `cfg_sync_xfer` = 0. It is issued one cycle after queueing when no transfer is active.
- R12: With `cfg_sync_xfer` = 1 and a nonzero block count, the queued command is held until the end of the last block. With a block count of 0 it is released at the end of a block.
- R13: A `cfg_wr` pulse while `cfg_lock` = 1 leaves the configuration unchanged.
- R14: Words leave the FIFO in the order they entered, in both directions. A push into a full FIFO is dropped. `host_pop` drains the FIFO in every state except `ST_RUN`, where `card_pop` is the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_lock | input | 1 | Write protection; 1 blocks configuration writes |
| cfg_eager | input | 1 | Start mode: 1 = start on one word, 0 = threshold by block length |
| cfg_flag_rs | input | 1 | Flag clear policy: 0 = by new command, 1 = by status read |
| cfg_sync_xfer | input | 1 | Queued command release: 0 = block end, 1 = transfer end |
| cfg_blk_len | input | LW | Block length in words (nonzero) |
| cmd_new | input | 1 | Starts a new transfer |
| cmd_write | input | 1 | Direction of the new transfer: 1 = write, 0 = read |
| cmd_blocks | input | BW | Block count of the new transfer; 0 = no end |
| cmd_pend | input | 1 | Queues a command for release |
| stat_rd | input | 1 | Status read strobe |
| host_push | input | 1 | Host writes a word into the FIFO |
| host_wdata | input | DW | Host write data |
| host_pop | input | 1 | Host takes a word from the FIFO |
| host_rdata | output | DW | Head word seen by the host |
| card_pop | input | 1 | Card engine takes a word (write) |
| card_rdata | output | DW | Head word seen by the card engine |
| card_push | input | 1 | Card engine stores a word (read) |
| card_wdata | input | DW | Card write data |
| xfer_go | output | 1 | Write block may be sent to the card |
| flag_unf | output | 1 | Underflow flag |
| flag_ovf | output | 1 | Overflow flag |
| cmd_issue | output | 1 | One-cycle release of the queued command |

## Verification
The start rule is swept over every block length from 1 to DEPTH in both start modes. Words are pushed one at a time, and `xfer_go` is checked after each push, which pins each threshold band and its boundary lengths 7/8 and 11/12. A draining sequence then shows that `xfer_go` holds until the last word and that data comes out in order. Underflow and overflow runs are repeated under both clear policies, so a stray clear source shows up as a mismatch. The queued-command runs count pops across three two-word blocks under each release setting, so an issue pulse one block early or late is caught. Write protection is tried by a locked write that would have changed the threshold.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2,
        ST_READ = 2'd3
    } cfs_state_e;
endpackage

// File: rtl/cfs_store.sv
module cfs_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    // R14: a push into a full FIFO without a pop leaves the level alone
    a_r14_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (level == CW'(DEPTH)));
    // R14: level never goes past the depth
    a_r14_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
endmodule

// File: rtl/cfs_thresh.sv
module cfs_thresh #(
    parameter int DEPTH = 32,
    parameter int LW    = 12,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          eager,
    input  logic [LW-1:0] blk_len,
    output logic [CW-1:0] thr
);
    localparam logic [LW-1:0] LEN_3Q = LW'((3 * DEPTH) / 4);
    localparam logic [LW-1:0] LEN_H  = LW'(DEPTH / 2);

    always_comb begin
        if (eager)                 thr = CW'(1);
        else if (blk_len >= LEN_3Q) thr = CW'(DEPTH / 2);
        else if (blk_len >= LEN_H)  thr = CW'(DEPTH / 4);
        else                        thr = CW'(blk_len);
    end
endmodule

// File: rtl/cfs_flags.sv
module cfs_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rs_mode,
    input  logic set_unf,
    input  logic set_ovf,
    input  logic cmd_new,
    input  logic stat_rd,
    output logic unf,
    output logic ovf
);
    logic clr;

    assign clr = rs_mode ? stat_rd : cmd_new;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unf <= 1'b0;
            ovf <= 1'b0;
        end else begin
            unf <= set_unf | (unf & ~clr);
            ovf <= set_ovf | (ovf & ~clr);
        end
    end

    // R10: status read clears when that policy is chosen
    a_r10_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_mode && stat_rd && !set_unf) |=> !unf);
    // R9: status read leaves the flag alone under the command policy
    a_r9_rd_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_mode && stat_rd && !cmd_new && ovf) |=> ovf);
endmodule

// File: rtl/cardfifo_start_ctrl.sv
module cardfifo_start_ctrl #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int LW    = 12,
    parameter int BW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_lock,
    input  logic          cfg_eager,
    input  logic          cfg_flag_rs,
    input  logic          cfg_sync_xfer,
    input  logic [LW-1:0] cfg_blk_len,
    input  logic          cmd_new,
    input  logic          cmd_write,
    input  logic [BW-1:0] cmd_blocks,
    input  logic          cmd_pend,
    input  logic          stat_rd,
    input  logic          host_push,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_pop,
    output logic [DW-1:0] host_rdata,
    input  logic          card_pop,
    output logic [DW-1:0] card_rdata,
    input  logic          card_push,
    input  logic [DW-1:0] card_wdata,
    output logic          xfer_go,
    output logic          flag_unf,
    output logic          flag_ovf,
    output logic          cmd_issue
);
    import cfs_pkg::*;

    localparam int CW = $clog2(DEPTH) + 1;

    cfs_state_e    state_q, state_d;
    logic          eager_q, rs_q, sync_q;
    logic [LW-1:0] len_q, wcnt_q;
    logic [BW-1:0] blocks_q, bdone_q;
    logic          pend_q, issue_q;

    logic          f_push, f_pop, f_full, f_empty;
    logic [DW-1:0] f_wdata, f_rdata;
    logic [CW-1:0] f_level, thr;
    logic          ge_thr, wr_word, rd_word, word_ev, blk_end, xfer_end;
    logic          set_unf, set_ovf, release_ok;

    // configuration register with write protection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eager_q <= 1'b0;
            rs_q    <= 1'b0;
            sync_q  <= 1'b0;
            len_q   <= LW'(DEPTH);
        end else if (cfg_wr && !cfg_lock) begin
            eager_q <= cfg_eager;
            rs_q    <= cfg_flag_rs;
            sync_q  <= cfg_sync_xfer;
            len_q   <= cfg_blk_len;
        end
    end

    cfs_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .push(f_push), .wdata(f_wdata),
        .pop(f_pop), .rdata(f_rdata), .level(f_level),
        .full(f_full), .empty(f_empty)
    );

    cfs_thresh #(.DEPTH(DEPTH), .LW(LW)) u_thresh (
        .eager(eager_q), .blk_len(len_q), .thr(thr)
    );

    cfs_flags u_flags (
        .clk(clk), .rst_n(rst_n), .rs_mode(rs_q), .set_unf(set_unf),
        .set_ovf(set_ovf), .cmd_new(cmd_new), .stat_rd(stat_rd),
        .unf(flag_unf), .ovf(flag_ovf)
    );

    // output and datapath decode
    always_comb begin
        f_push     = (state_q == ST_READ) ? card_push : host_push;
        f_wdata    = (state_q == ST_READ) ? card_wdata : host_wdata;
        f_pop      = (state_q == ST_RUN) ? card_pop : host_pop;
        host_rdata = f_rdata;
        card_rdata = f_rdata;
        xfer_go    = (state_q == ST_RUN);
        cmd_issue  = issue_q;
        ge_thr     = (f_level >= thr);
        wr_word    = (state_q == ST_RUN) && card_pop && !f_empty;
        rd_word    = (state_q == ST_READ) && card_push && !f_full;
        word_ev    = wr_word | rd_word;
        blk_end    = word_ev && (wcnt_q == len_q - LW'(1));
        xfer_end   = (blocks_q != '0) && (bdone_q == blocks_q - BW'(1));
        set_unf    = (state_q == ST_RUN) && card_pop && f_empty;
        set_ovf    = (state_q == ST_READ) && card_push && f_full;
        release_ok = pend_q && ((state_q == ST_IDLE) ||
                     (blk_end && (!sync_q || blocks_q == '0 || xfer_end)));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_FILL: if (ge_thr) state_d = ST_RUN;
            ST_RUN:  if (blk_end) state_d = xfer_end ? ST_IDLE : ST_FILL;
            ST_READ: if (blk_end && xfer_end) state_d = ST_IDLE;
        endcase
        if (cmd_new) state_d = cmd_write ? ST_FILL : ST_READ;
    end

    // state register and transfer counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wcnt_q   <= '0;
            bdone_q  <= '0;
            blocks_q <= '0;
            pend_q   <= 1'b0;
            issue_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cmd_new) begin
                wcnt_q   <= '0;
                bdone_q  <= '0;
                blocks_q <= cmd_blocks;
            end else if (blk_end) begin
                wcnt_q  <= '0;
                bdone_q <= bdone_q + BW'(1);
            end else if (word_ev) begin
                wcnt_q <= wcnt_q + LW'(1);
            end
            issue_q <= release_ok;
            pend_q  <= (pend_q && !release_ok) || cmd_pend;
        end
    end

    // R2: a write block only starts once the fill threshold was met
    a_r2_start_on_thr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_go) |-> $past(ge_thr));
    // R7: an empty-FIFO pop during a running block raises underflow
    a_r7_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go && card_pop && f_empty) |=> flag_unf);
    // R8: a full-FIFO push during a read raises overflow
    a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && card_push && f_full) |=> flag_ovf);
    // R11: an issue pulse always follows a queued command
    a_r11_issue_queued: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> $past(pend_q));
    // R13: locked configuration stays put
    a_r13_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> $stable({eager_q, rs_q, sync_q, len_q}));
endmodule

// File: tb/cardfifo_start_ctrl_bench.sv
module cardfifo_start_ctrl_bench;
    localparam int D  = 16;
    localparam int DW = 8;
    localparam int LW = 8;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 0, cfg_lock = 0, cfg_eager = 0, cfg_flag_rs = 0, cfg_sync_xfer = 0;
    logic [LW-1:0] cfg_blk_len = '0;
    logic          cmd_new = 0, cmd_write = 0, cmd_pend = 0, stat_rd = 0;
    logic [BW-1:0] cmd_blocks = '0;
    logic          host_push = 0, host_pop = 0, card_pop = 0, card_push = 0;
    logic [DW-1:0] host_wdata = '0, card_wdata = '0;
    logic [DW-1:0] host_rdata, card_rdata;
    logic          xfer_go, flag_unf, flag_ovf, cmd_issue;

    int vec = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cardfifo_start_ctrl #(.DEPTH(D), .DW(DW), .LW(LW), .BW(BW)) u_cardfifo_start_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_lock(cfg_lock),
        .cfg_eager(cfg_eager), .cfg_flag_rs(cfg_flag_rs), .cfg_sync_xfer(cfg_sync_xfer),
        .cfg_blk_len(cfg_blk_len), .cmd_new(cmd_new), .cmd_write(cmd_write),
        .cmd_blocks(cmd_blocks), .cmd_pend(cmd_pend), .stat_rd(stat_rd),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
        .host_rdata(host_rdata), .card_pop(card_pop), .card_rdata(card_rdata),
        .card_push(card_push), .card_wdata(card_wdata), .xfer_go(xfer_go),
        .flag_unf(flag_unf), .flag_ovf(flag_ovf), .cmd_issue(cmd_issue)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic e, input logic rs, input logic sy, input int len);
        cfg_eager = e; cfg_flag_rs = rs; cfg_sync_xfer = sy; cfg_blk_len = LW'(len);
        cfg_wr = 1'b1; @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic cmd(input logic wr, input int blocks);
        cmd_write = wr; cmd_blocks = BW'(blocks);
        cmd_new = 1'b1; @(negedge clk); cmd_new = 1'b0;
    endtask

    task automatic hpush(input int d);
        host_wdata = DW'(d); host_push = 1'b1; @(negedge clk); host_push = 1'b0;
    endtask

    task automatic hpop(output int d);
        d = int'(host_rdata); host_pop = 1'b1; @(negedge clk); host_pop = 1'b0;
    endtask

    task automatic cpush(input int d);
        card_wdata = DW'(d); card_push = 1'b1; @(negedge clk); card_push = 1'b0;
    endtask

    task automatic cpop(output int d, output int iss);
        d = int'(card_rdata); card_pop = 1'b1; @(negedge clk); card_pop = 1'b0;
        iss = int'(cmd_issue);
    endtask

    task automatic pulse_stat();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pulse_pend();
        cmd_pend = 1'b1; @(negedge clk); cmd_pend = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run ended)");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        int d, iss, thr;
        string tag;
        idle(2);
        // R1: outputs during and right after reset
        chk("R1 go", int'(xfer_go), 0);
        chk("R1 unf", int'(flag_unf), 0);
        chk("R1 ovf", int'(flag_ovf), 0);
        chk("R1 issue", int'(cmd_issue), 0);
        rst_n = 1'b1;
        idle(1);
        // R1: default config gives length D, threshold D/2
        cmd(1'b1, 1);
        for (int p = 1; p <= D; p++) begin
            hpush(p);
            idle(1);
            chk("R1 default threshold", int'(xfer_go), (p >= D / 2) ? 1 : 0);
        end
        for (int i = 1; i <= D; i++) begin
            cpop(d, iss);
            chk("R1 drain data", d, i);
        end
        chk("R1 idle after block", int'(xfer_go), 0);

        // R2..R6, R14: sweep of start mode and block length
        for (int e = 0; e <= 1; e++) begin
            for (int len = 1; len <= D; len++) begin
                if (e == 1) begin thr = 1; tag = "R2"; end
                else if (len >= (3 * D) / 4) begin thr = D / 2; tag = "R3"; end
                else if (len >= D / 2) begin thr = D / 4; tag = "R4"; end
                else begin thr = len; tag = "R5"; end
                cfg(e[0], 1'b0, 1'b0, len);
                cmd(1'b1, 1);
                chk({tag, " before data"}, int'(xfer_go), 0);
                for (int p = 1; p <= len; p++) begin
                    hpush(p + 32);
                    idle(1);
                    chk({tag, " start point"}, int'(xfer_go), (p >= thr) ? 1 : 0);
                end
                for (int i = 1; i <= len; i++) begin
                    chk("R6 go held", int'(xfer_go), 1);
                    cpop(d, iss);
                    chk("R14 order", d, i + 32);
                end
                chk("R6 go drops after last word", int'(xfer_go), 0);
            end
        end

        // R6: two blocks re-evaluate the start, then idle
        cfg(1'b1, 1'b0, 1'b0, 2);
        cmd(1'b1, 2);
        for (int b = 0; b < 2; b++) begin
            hpush(1); hpush(2); idle(1);
            chk("R6 block start", int'(xfer_go), 1);
            cpop(d, iss); cpop(d, iss);
            chk("R6 block end", int'(xfer_go), 0);
        end
        hpush(7); idle(2);
        chk("R6 idle after last block", int'(xfer_go), 0);
        hpop(d);
        chk("R14 host drain in idle", d, 7);

        // R7, R9: underflow, cleared only by a new command
        cfg(1'b1, 1'b0, 1'b0, 4);
        cmd(1'b1, 1);
        hpush(1); idle(1);
        cpop(d, iss);
        cpop(d, iss);
        chk("R7 underflow set", int'(flag_unf), 1);
        pulse_stat();
        chk("R9 status read ignored", int'(flag_unf), 1);
        hpush(2); hpush(3); hpush(4);
        cpop(d, iss); cpop(d, iss);
        chk("R7 empty pop not counted", int'(xfer_go), 1);
        cpop(d, iss);
        chk("R7 block ends on fourth word", int'(xfer_go), 0);
        cmd(1'b0, 1);
        chk("R9 command clears", int'(flag_unf), 0);
        for (int i = 0; i < 4; i++) cpush(50 + i);
        for (int i = 0; i < 4; i++) begin
            hpop(d);
            chk("R14 read order", d, 50 + i);
        end

        // R8, R10: overflow, cleared only by a status read
        cfg(1'b0, 1'b1, 1'b0, 20);
        cmd(1'b0, 1);
        for (int i = 1; i <= D; i++) cpush(100 + i);
        chk("R8 no overflow at full", int'(flag_ovf), 0);
        cpush(200);
        chk("R8 overflow set", int'(flag_ovf), 1);
        for (int i = 1; i <= D; i++) begin
            hpop(d);
            chk("R8 overflow word dropped", d, 100 + i);
        end
        cmd(1'b0, 1);
        chk("R10 command ignored", int'(flag_ovf), 1);
        pulse_stat();
        chk("R10 status read clears", int'(flag_ovf), 0);
        cfg(1'b0, 1'b1, 1'b0, 2);
        cpush(1); cpush(2);
        hpop(d); hpop(d);

        // R11: queued command issues at once when idle
        pulse_pend();
        chk("R11 not yet", int'(cmd_issue), 0);
        idle(1);
        chk("R11 idle release", int'(cmd_issue), 1);
        idle(1);
        chk("R11 single pulse", int'(cmd_issue), 0);

        // R11, R12: release point over three two-word blocks
        for (int c = 0; c < 3; c++) begin
            int sy, blk, want;
            sy   = (c == 0) ? 0 : 1;
            blk  = (c == 2) ? 0 : 3;
            want = (c == 1) ? 6 : 2;
            cfg(sy[0], 1'b0, sy[0], 2);
            cmd(1'b1, blk);
            pulse_pend();
            for (int b = 0; b < 3; b++) begin
                hpush(1); hpush(2); idle(1);
                for (int k = 1; k <= 2; k++) begin
                    cpop(d, iss);
                    chk((c == 0) ? "R11 block release" : "R12 sync release",
                        iss, (b * 2 + k == want) ? 1 : 0);
                end
            end
            if (blk == 0) begin
                cmd(1'b0, 1);
                cpush(1); cpush(2);
                hpop(d); hpop(d);
            end
        end

        // R13: locked configuration write is ignored
        cfg(1'b0, 1'b0, 1'b0, D);
        cfg_lock = 1'b1;
        cfg(1'b1, 1'b0, 1'b0, 4);
        cfg_lock = 1'b0;
        cmd(1'b1, 1);
        for (int p = 1; p <= D; p++) begin
            hpush(p);
            idle(1);
            chk("R13 old threshold kept", int'(xfer_go), (p >= D / 2) ? 1 : 0);
        end
        for (int i = 1; i <= D; i++) cpop(d, iss);
        chk("R13 length kept", int'(xfer_go), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule